// File: doc/BRIEF.md
# Atomic Memory Read-Modify-Write Unit

This unit carries out the atomic store-class instructions of a small 64-bit register machine against a single-port synchronous data memory whose read data arrives one cycle after the request. A decoder upstream hands it the opcode byte, the 32-bit immediate, the values of the base (destination) register, the source register and register 0, the source register index and a signed 16-bit displacement. The unit checks that the request is an atomic instruction, forms the effective byte address, reads the old memory word, computes the new word, writes it back and reports the old value together with a register write-back target.

The immediate, not the opcode, picks the operation: add, or, and, xor (each with or without returning the old value), exchange and compare-exchange. The opcode picks a 32-bit or 64-bit access. Between the read and the write the unit stays busy and accepts no other request, so no other access can fall between them.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Only opcode 0xc3 (32-bit) and 0xdb (64-bit) are atomic; any other opcode completes with err_illegal high, wb_en low and no memory access.
- R2: The effective address is the base value plus the sign-extended displacement; mem_addr carries byte address bits above bit 2, and for 32-bit accesses byte address bit 2 selects the upper half (mem_be 0xF0) or lower half (mem_be 0x0F).
- R3: A 64-bit access whose byte address has any of bits 2..0 set, or a 32-bit access with any of bits 1..0 set, completes with err_misalign high, wb_en low and no memory access.
- R4: Immediates 0x00, 0x40, 0x50 and 0xa0 store old+src, old|src, old&src and old^src respectively and give no register write-back.
- R5: The same immediates with bit 0 set (0x01, 0x41, 0x51, 0xa1) make the same memory update and write the old memory value to the source register index.
- R6: Immediate 0xe1 stores the source value and writes the old memory value to the source register index.
- R7: Immediate 0xf1 compares the old value with register 0 (its low 32 bits in 32-bit form); memory takes the source value only on a match, with one read and no write on a mismatch, and register index 0 always receives the old value.
- R8: 32-bit forms use the low 32 bits of the source, wrap arithmetic in 32 bits, leave the other half of the memory word unchanged, and zero-extend the returned old value.
- R9: Any other immediate value (e.g. 0x02, 0xe0, 0x100) completes with err_illegal high, wb_en low and no memory access.
- R10: req_ready is high only when idle; an accepted legal request reads in the next cycle, writes in the one after, and pulses done for one cycle three cycles after acceptance (one cycle for a rejected request), with busy high from acceptance through done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_opcode | input | 8 | Instruction opcode byte |
| req_imm | input | 32 | Immediate selecting the operation |
| req_base | input | 64 | Base (destination) register value |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Register 0 value |
| req_src_idx | input | 4 | Source register index |
| req_disp | input | 16 | Signed address displacement |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_be | output | 8 | Byte enables for a write |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 4 | Write-back register index |
| wb_data | output | 64 | Write-back value |
| err_illegal | output | 1 | Request was not a legal atomic operation |
| err_misalign | output | 1 | Address was not naturally aligned |

## Verification
The comparison against register 0 and the write it gates fall in the same modify cycle, so a compare-exchange decides and writes, or skips the write, at one edge. The bench issues a matching and then a mismatching compare-exchange to the same word, plus a 32-bit one where register 0 differs only in its upper half, and judges each by the full memory image, the number of memory cycles used and the value returned to register 0.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam logic [7:0] OPC_ATOM32 = 8'hc3;
  localparam logic [7:0] OPC_ATOM64 = 8'hdb;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MOD, ST_RESP} amo_state_e;
  typedef enum logic [2:0] {OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CAS, OP_BAD} amo_op_e;

  typedef struct packed {
    amo_op_e op;
    logic    fetch;
    logic    legal;
  } amo_dec_t;

  function automatic amo_dec_t decode_imm(input logic [31:0] imm);
    amo_dec_t d;
    d.fetch = imm[0];
    d.legal = 1'b1;
    case (imm)
      32'h00, 32'h01: d.op = OP_ADD;
      32'h40, 32'h41: d.op = OP_OR;
      32'h50, 32'h51: d.op = OP_AND;
      32'ha0, 32'ha1: d.op = OP_XOR;
      32'he1:         d.op = OP_XCHG;
      32'hf1:         d.op = OP_CAS;
      default: begin
        d.op    = OP_BAD;
        d.legal = 1'b0;
      end
    endcase
    return d;
  endfunction

  function automatic logic [63:0] alu_apply(input amo_op_e op, input logic [63:0] a,
                                            input logic [63:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_OR:   return a | b;
      OP_AND:  return a & b;
      OP_XOR:  return a ^ b;
      default: return b;
    endcase
  endfunction
endpackage

// File: rtl/amo_addr.sv
module amo_addr #(
  parameter int ADDR_W = 16
) (
  input  logic [63:0]       base,
  input  logic [15:0]       disp,
  input  logic              is32,
  output logic [ADDR_W-1:0] word_addr,
  output logic              upper,
  output logic              misalign
);
  logic [63:0] ea;
  assign ea        = base + {{48{disp[15]}}, disp};
  assign word_addr = ea[ADDR_W+2:3];
  assign upper     = ea[2];
  assign misalign  = is32 ? (|ea[1:0]) : (|ea[2:0]);
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  amo_op_e     op,
  input  logic        is32,
  input  logic        upper,
  input  logic [63:0] rdata,
  input  logic [63:0] src,
  input  logic [63:0] r0,
  output logic [63:0] old_val,
  output logic [63:0] wdata,
  output logic [7:0]  be,
  output logic        cas_match,
  output logic        do_write
);
  logic [63:0] src_eff;
  logic [63:0] new_val;

  assign old_val   = is32 ? {32'b0, (upper ? rdata[63:32] : rdata[31:0])} : rdata;
  assign src_eff   = is32 ? {32'b0, src[31:0]} : src;
  assign new_val   = alu_apply(op, old_val, src_eff);
  assign wdata     = is32 ? {new_val[31:0], new_val[31:0]} : new_val;
  assign be        = is32 ? (upper ? 8'hF0 : 8'h0F) : 8'hFF;
  assign cas_match = is32 ? (old_val[31:0] == r0[31:0]) : (old_val == r0);
  assign do_write  = (op != OP_CAS) || cas_match;
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [31:0]       req_imm,
  input  logic [63:0]       req_base,
  input  logic [63:0]       req_src,
  input  logic [63:0]       req_r0,
  input  logic [IDX_W-1:0]  req_src_idx,
  input  logic [15:0]       req_disp,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [63:0]       wb_data,
  output logic              err_illegal,
  output logic              err_misalign
);
  amo_state_e state;

  // request decode on the incoming fields
  logic     in_is32, in_opc_ok, in_legal, in_upper, in_mis;
  logic [ADDR_W-1:0] in_waddr;
  amo_dec_t in_dec;
  logic     accept;

  assign in_opc_ok = (req_opcode == OPC_ATOM32) || (req_opcode == OPC_ATOM64);
  assign in_is32   = (req_opcode == OPC_ATOM32);
  assign in_dec    = decode_imm(req_imm);
  assign in_legal  = in_opc_ok && in_dec.legal;
  assign accept    = req_valid && req_ready;

  amo_addr #(.ADDR_W(ADDR_W)) u_addr (
    .base(req_base), .disp(req_disp), .is32(in_is32),
    .word_addr(in_waddr), .upper(in_upper), .misalign(in_mis)
  );

  // latched request
  amo_op_e           r_op;
  logic              r_is32, r_fetch, r_upper, r_ill, r_mis;
  logic [63:0]       r_src, r_r0;
  logic [IDX_W-1:0]  r_idx;
  logic [ADDR_W-1:0] r_waddr;
  logic              r_wb_en;
  logic [IDX_W-1:0]  r_wb_idx;
  logic [63:0]       r_wb_data;

  // modify-stage results, brought out for checking
  logic [63:0] alu_old, alu_wdata;
  logic [7:0]  alu_be;
  logic        alu_cas_match, alu_do_write;

  amo_alu u_alu (
    .op(r_op), .is32(r_is32), .upper(r_upper), .rdata(mem_rdata),
    .src(r_src), .r0(r_r0), .old_val(alu_old), .wdata(alu_wdata),
    .be(alu_be), .cas_match(alu_cas_match), .do_write(alu_do_write)
  );

  logic in_mod;
  assign in_mod = (state == ST_MOD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_op      <= OP_ADD;
      r_is32    <= 1'b0;
      r_fetch   <= 1'b0;
      r_upper   <= 1'b0;
      r_ill     <= 1'b0;
      r_mis     <= 1'b0;
      r_src     <= '0;
      r_r0      <= '0;
      r_idx     <= '0;
      r_waddr   <= '0;
      r_wb_en   <= 1'b0;
      r_wb_idx  <= '0;
      r_wb_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          r_op     <= in_dec.op;
          r_is32   <= in_is32;
          r_fetch  <= in_dec.fetch;
          r_upper  <= in_upper;
          r_ill    <= !in_legal;
          r_mis    <= in_legal && in_mis;
          r_src    <= req_src;
          r_r0     <= req_r0;
          r_idx    <= req_src_idx;
          r_waddr  <= in_waddr;
          r_wb_en  <= 1'b0;
          state    <= (!in_legal || in_mis) ? ST_RESP : ST_READ;
        end
        ST_READ: state <= ST_MOD;
        ST_MOD: begin
          r_wb_en   <= r_fetch;
          r_wb_idx  <= (r_op == OP_CAS) ? '0 : r_idx;
          r_wb_data <= alu_old;
          state     <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_RESP);
  assign mem_en       = (state == ST_READ) || (in_mod && alu_do_write);
  assign mem_we       = in_mod && alu_do_write;
  assign mem_addr     = r_waddr;
  assign mem_be       = alu_be;
  assign mem_wdata    = alu_wdata;
  assign wb_en        = done && r_wb_en;
  assign wb_idx       = r_wb_idx;
  assign wb_data      = r_wb_data;
  assign err_illegal  = done && r_ill;
  assign err_misalign = done && r_mis;

  // R10: a write is always preceded by the read of the same operation
  a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_en && !mem_we));
  // R10: memory is only touched while the unit holds busy
  a_r10_access_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);
  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1 / R3 / R9: rejected requests never reach memory
  a_r1_reject_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_illegal || err_misalign)) |-> (!$past(mem_en) && !wb_en));
  // R7: compare-exchange writes only on a match
  a_r7_cas_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && r_op == OP_CAS) |-> alu_cas_match);
  // R8: a 32-bit write covers exactly one half of the word
  a_r8_half_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && r_is32) |-> ($countones(mem_be) == 4));
endmodule

// File: tb/test_atomic_rmw_unit.sv
module test_atomic_rmw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = '0;
  logic [31:0] req_imm = '0;
  logic [63:0] req_base = '0, req_src = '0, req_r0 = '0;
  logic [3:0]  req_src_idx = '0;
  logic [15:0] req_disp = '0;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        busy, done, wb_en, err_illegal, err_misalign;
  logic [3:0]  wb_idx;
  logic [63:0] wb_data;

  int errors = 0;
  int checks = 0;
  int acc_cnt = 0;
  logic [63:0] mem [16];

  always #5 clk = ~clk;

  atomic_rmw_unit i_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_imm(req_imm), .req_base(req_base),
    .req_src(req_src), .req_r0(req_r0), .req_src_idx(req_src_idx),
    .req_disp(req_disp), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .err_illegal(err_illegal), .err_misalign(err_misalign)
  );

  // memory model: synchronous, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      mem_rdata <= mem[mem_addr[3:0]];
      if (mem_we)
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // independent model of one operation on a memory word
  task automatic model(input logic [31:0] imm, input logic w32, input logic up,
                       input logic [63:0] word, input logic [63:0] src, input logic [63:0] r0,
                       output logic [63:0] nword, output logic wr, output logic [63:0] oldv);
    logic [63:0] s, n;
    oldv = w32 ? (up ? {32'b0, word[63:32]} : {32'b0, word[31:0]}) : word;
    s = w32 ? {32'b0, src[31:0]} : src;
    wr = 1'b1;
    unique case (imm[7:4])
      4'h0: n = oldv + s;
      4'h4: n = oldv | s;
      4'h5: n = oldv & s;
      4'ha: n = oldv ^ s;
      4'he: n = s;
      default: begin
        n = s;
        wr = w32 ? (oldv[31:0] == r0[31:0]) : (oldv == r0);
      end
    endcase
    nword = word;
    if (wr) begin
      if (!w32) nword = n;
      else if (up) nword[63:32] = n[31:0];
      else nword[31:0] = n[31:0];
    end
  endtask

  task automatic run_req(input string rq, input logic [7:0] opc, input logic [31:0] imm,
                         input logic [63:0] base, input logic [63:0] src, input logic [63:0] r0,
                         input logic [3:0] sidx, input logic [15:0] disp,
                         input logic exp_ill, input logic exp_mis);
    logic [63:0] ea, nword, oldv;
    logic [63:0] expm [16];
    logic w32, up, wr, rej;
    int widx, n, exp_acc, exp_lat;
    ea   = base + {{48{disp[15]}}, disp};
    widx = int'(ea[6:3]);
    up   = ea[2];
    w32  = (opc == 8'hc3);
    rej  = exp_ill || exp_mis;
    for (int i = 0; i < 16; i++) expm[i] = mem[i];
    wr = 1'b0; oldv = '0;
    if (!rej) begin
      model(imm, w32, up, mem[widx], src, r0, nword, wr, oldv);
      expm[widx] = nword;
    end
    exp_acc = rej ? 0 : (wr ? 2 : 1);
    exp_lat = rej ? 1 : 3;
    req_opcode = opc; req_imm = imm; req_base = base; req_src = src;
    req_r0 = r0; req_src_idx = sidx; req_disp = disp; req_valid = 1'b1;
    acc_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk("R10", "busy after accept", busy, 1'b1);
    chk("R10", "ready while busy", req_ready, 1'b0);
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R10", "latency", n, exp_lat);
    chk(rq, "err_illegal", err_illegal, exp_ill);
    chk(rq, "err_misalign", err_misalign, exp_mis);
    chk(rq, "wb_en", wb_en, !rej && imm[0]);
    if (!rej && imm[0]) begin
      chk(rq, "wb_idx", wb_idx, (imm == 32'hf1) ? 4'd0 : sidx);
      chk(rq, "wb_data", wb_data, oldv);
    end
    chk(rq, "memory cycles", acc_cnt, exp_acc);
    for (int i = 0; i < 16; i++)
      if (mem[i] !== expm[i]) chk(rq, $sformatf("mem[%0d]", i), mem[i], expm[i]);
    checks++;
    @(negedge clk);
    chk("R10", "done pulse", done, 1'b0);
  endtask

  task automatic t_reset();
    chk("R10", "ready at reset", req_ready, 1'b1);
    chk("R10", "busy at reset", busy, 1'b0);
    chk("R10", "done at reset", done, 1'b0);
    chk("R10", "mem_en at reset", mem_en, 1'b0);
  endtask

  task automatic t_decode();  // R1
    run_req("R1", 8'h7b, 32'h0, 64'h10, 64'h5, 64'h0, 4'd2, 16'h0, 1'b1, 1'b0);
    run_req("R1", 8'hcb, 32'h0, 64'h10, 64'h5, 64'h0, 4'd2, 16'h0, 1'b1, 1'b0);
    run_req("R1", 8'hdb, 32'h0, 64'h10, 64'h5, 64'h0, 4'd2, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_alu64();  // R4
    run_req("R4", 8'hdb, 32'h00, 64'h18, 64'h0000_0001_0000_0010, 64'h0, 4'd1, 16'h0, 1'b0, 1'b0);
    run_req("R4", 8'hdb, 32'h40, 64'h20, 64'h0F00_0000_0000_000F, 64'h0, 4'd1, 16'h0, 1'b0, 1'b0);
    run_req("R4", 8'hdb, 32'h50, 64'h28, 64'hFFFF_0000_FFFF_00FF, 64'h0, 4'd1, 16'h0, 1'b0, 1'b0);
    run_req("R4", 8'hdb, 32'ha0, 64'h30, 64'hAAAA_5555_AAAA_5555, 64'h0, 4'd1, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_fetch();  // R5
    run_req("R5", 8'hdb, 32'h01, 64'h38, 64'h7, 64'h0, 4'd3, 16'h0, 1'b0, 1'b0);
    run_req("R5", 8'hdb, 32'h41, 64'h38, 64'hF0, 64'h0, 4'd5, 16'h0, 1'b0, 1'b0);
    run_req("R5", 8'hdb, 32'h51, 64'h38, 64'hFFFF_FFFF_0000_FFFF, 64'h0, 4'd6, 16'h0, 1'b0, 1'b0);
    run_req("R5", 8'hdb, 32'ha1, 64'h38, 64'h1234_5678_9ABC_DEF0, 64'h0, 4'd9, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_xchg();  // R6
    run_req("R6", 8'hdb, 32'he1, 64'h50, 64'hCAFE_F00D_0000_0001, 64'h0, 4'd7, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_cas();  // R7: hit, then miss on the same word, then 32-bit hit with R0 upper half differing
    run_req("R7", 8'hdb, 32'hf1, 64'h58, 64'h1111_2222_3333_4444, mem[11], 4'd4, 16'h0, 1'b0, 1'b0);
    run_req("R7", 8'hdb, 32'hf1, 64'h58, 64'h9999, 64'h0, 4'd4, 16'h0, 1'b0, 1'b0);
    run_req("R7", 8'hc3, 32'hf1, 64'h60, 64'hFFFF_FFFF_0000_0077,
            {32'hDEAD_BEEF, mem[12][31:0]}, 4'd4, 16'h0, 1'b0, 1'b0);
    run_req("R7", 8'hc3, 32'hf1, 64'h60, 64'h55, {32'h0, ~mem[12][31:0]}, 4'd4, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_word32();  // R8 and R2: upper half via negative displacement, 32-bit wrap
    mem[5] = {32'hFFFF_FFFF, 32'h1357_9BDF};
    run_req("R8", 8'hc3, 32'h01, 64'h30, 64'hDEAD_0000_0000_0002, 64'h0, 4'd8, 16'hFFFC, 1'b0, 1'b0);
    chk("R8", "upper half wrapped", mem[5], {32'h0000_0001, 32'h1357_9BDF});
    run_req("R8", 8'hc3, 32'ha1, 64'h28, 64'hFFFF_FFFF_0000_FFFF, 64'h0, 4'd2, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_addr();  // R2
    run_req("R2", 8'hdb, 32'h00, 64'h100, 64'h3, 64'h0, 4'd1, 16'hFF40, 1'b0, 1'b0);
    run_req("R2", 8'hdb, 32'h00, 64'h0, 64'h4, 64'h0, 4'd1, 16'h0070, 1'b0, 1'b0);
  endtask

  task automatic t_misalign();  // R3
    run_req("R3", 8'hdb, 32'h01, 64'h14, 64'h1, 64'h0, 4'd1, 16'h0, 1'b0, 1'b1);
    run_req("R3", 8'hc3, 32'h01, 64'h10, 64'h1, 64'h0, 4'd1, 16'h2, 1'b0, 1'b1);
    run_req("R3", 8'hc3, 32'h01, 64'h14, 64'h1, 64'h0, 4'd1, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_illegal_imm();  // R9
    run_req("R9", 8'hdb, 32'he0, 64'h18, 64'h1, 64'h0, 4'd1, 16'h0, 1'b1, 1'b0);
    run_req("R9", 8'hdb, 32'h02, 64'h18, 64'h1, 64'h0, 4'd1, 16'h0, 1'b1, 1'b0);
    run_req("R9", 8'hc3, 32'h100, 64'h18, 64'h1, 64'h0, 4'd1, 16'h0, 1'b1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = {32'h8000_0000 | i, 32'hFFFF_FFF0 + i};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_alu64();
    t_fetch();
    t_xchg();
    t_cas();
    t_word32();
    t_addr();
    t_misalign();
    t_illegal_imm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule